// File: doc/BRIEF.md
# Sequential-Access Configuration Register Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (SCL clock, SDA data) that holds a small bank of configuration bytes. It samples both bus lines with a fast system clock, finds the Start and Stop conditions and the SCL edges, and runs a byte-level state machine. SDA is open drain: the block never drives it high; it only asserts a pull-low enable, which the pad logic turns into an open-drain driver.

Access is block-oriented and strictly sequential. A write transfer carries two leading bytes that the target acknowledges and throws away, a command code and a byte count, and then a run of data bytes that fill the bank from byte 0 upward. A read transfer returns a byte count first and then the bank contents from byte 0 upward. There is no random addressing: each Start, including a repeated Start, begins again at the first byte. The bank contents are always visible in parallel, and the bank loads a default image from an input bus while reset is held.

Top module: `cfg_i2c_slave`

## Requirements
- R1: While rst_n is low at a clock edge, the bank loads rst_val_i (byte k at bits 8k+7..8k of both rst_val_i and regs_o) and SDA is released (sda_pull_o = 0).
- R2: The block acknowledges only the address bytes 0xD2 (write) and 0xD3 (read); any other address byte and every byte after it up to the next Start gets no acknowledge, changes no register, and SDA stays released while the block is idle.
- R3: In a write transfer the two bytes after the address (command code, byte count) are acknowledged and their values change no register.
- R4: Data bytes of a write transfer, received MSB first, load byte 0, byte 1, and so on in that order, and each one is acknowledged.
- R5: A Stop after any complete data byte keeps every byte already loaded and leaves the remaining bytes unchanged; a data byte cut short by a Stop is not written.
- R6: Data bytes beyond the last bank byte are acknowledged and discarded.
- R7: A read transfer returns, MSB first, the byte count 0x06 and then bytes 0 to 5 in order; items requested after byte 5 read as 0xFF (SDA released).
- R8: When the host does not acknowledge a read byte, the block releases SDA and ignores SCL until the next Start.
- R9: A repeated Start returns the byte pointer to the beginning: a following write again treats its first two bytes as command code and byte count, and a following read again starts with the byte count.
- R10: The block changes sda_pull_o only while SCL is low.
- R11: A read transfer changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Pull SDA low when 1, release when 0 |
| rst_val_i | input | 48 | Default image loaded into the bank during reset, byte k at bits 8k+7..8k |
| regs_o | output | 48 | Parallel view of the bank, byte k at bits 8k+7..8k |

## Verification
The assertions take for granted that the host moves SDA only while SCL is low, except for its own Start and Stop conditions, and that each SCL high and low phase lasts longer than the synchronizer latency of three system clocks; they also assume the host releases SDA whenever the block owns an acknowledge or read-data slot. The bench model of the bus holds every SCL quarter period at eight system clocks, changes its own SDA pull only in the middle of SCL low phases, and releases SDA before every acknowledge slot it does not own, so the stimulus never leaves that envelope. Under those conditions the bench sweeps every write length from zero to eight data bytes, reads back after each, and runs the wrong-address, cut-byte, repeated-Start and host-NACK cases.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  // Byte-level protocol states of the target.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;

  // Transfer item index: counts bytes moved since the last Start.
  typedef logic [7:0] idx_t;

  // True when the received address byte selects this target (R/W bit ignored).
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] dev);
    return rx[7:1] == dev;
  endfunction

  // Saturating increment of the item index.
  function automatic idx_t sat_inc(input idx_t i, input idx_t lim);
    return (i < lim) ? i + 8'd1 : i;
  endfunction

  // Write items 0 and 1 are command code and byte count; bank data starts at 2.
  function automatic logic wr_slot(input idx_t i, input idx_t nregs);
    return (i >= 8'd2) && ((i - 8'd2) < nregs);
  endfunction

  function automatic idx_t wr_target(input idx_t i);
    return i - 8'd2;
  endfunction

  // Read item 0 is the byte count; bank data starts at 1.
  function automatic idx_t rd_target(input idx_t i);
    return i - 8'd1;
  endfunction

endpackage

// File: rtl/cfgi2c_pin_sync.sv
module cfgi2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // Idle bus is high on both lines, so the pipeline resets high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_pipe[k] <= scl_pipe[k-1];
        sda_pipe[k] <= sda_pipe[k-1];
      end
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // SDA moving while SCL stays high marks a bus condition.
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;

endmodule

// File: rtl/cfgi2c_reg_bank.sv
module cfgi2c_reg_bank #(
  parameter int NUM_REGS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REGS*8-1:0] rst_val_i,
  input  logic                  we_i,
  input  logic [7:0]            widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            ridx_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam logic [7:0] NUM_B = 8'(NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= rst_val_i[g*8 +: 8];
      end else if (we_i && (widx_i == 8'(g))) begin
        q <= wdata_i;
      end
    end
    assign regs_o[g*8 +: 8] = q;
  end

  // Out-of-range reads return all ones, which leaves SDA released.
  always_comb begin
    rdata_o = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (ridx_i == 8'(k)) rdata_o = regs_o[k*8 +: 8];
    end
  end

  // R6
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (widx_i < NUM_B));

endmodule

// File: rtl/cfgi2c_fsm.sv
module cfgi2c_fsm
  import cfgi2c_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_s_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rdata_i,
  output logic       sda_pull_o,
  output logic       we_o,
  output logic [7:0] widx_o,
  output logic [7:0] wdata_o,
  output logic [7:0] ridx_o
);

  localparam idx_t       NUM_B      = 8'(NUM_REGS);
  localparam idx_t       IDX_LIM    = NUM_B + 8'd2;
  localparam logic [7:0] BYTE_COUNT = 8'(NUM_REGS);

  slv_state_e st;
  logic [3:0] bit_cnt;
  logic [7:0] sh;
  logic [7:0] txsh;
  idx_t       idx;
  logic       rw_q;
  logic       m_ack;
  logic       pull_q;
  logic [7:0] tx_item;
  logic       byte_in;

  assign sda_pull_o = pull_q;
  assign byte_in    = (bit_cnt == 4'd8);
  assign tx_item    = (idx == 8'd0) ? BYTE_COUNT : rdata_i;
  assign ridx_o     = rd_target(idx);
  assign widx_o     = wr_target(idx);
  assign wdata_o    = sh;
  assign we_o       = (st == ST_RX) && scl_fall_i && byte_in && !start_i && !stop_i
                      && wr_slot(idx, NUM_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      txsh    <= '0;
      idx     <= '0;
      rw_q    <= 1'b0;
      m_ack   <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      idx     <= '0;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      st      <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          pull_q <= 1'b0;
        end
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh      <= {sh[6:0], sda_s_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall_i && byte_in) begin
            if (addr_hit(sh, DEV_ADDR)) begin
              rw_q   <= sh[0];
              pull_q <= 1'b1;
              st     <= ST_ADDR_ACK;
            end else begin
              st     <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (rw_q) begin
              pull_q <= ~tx_item[7];
              txsh   <= tx_item << 1;
              idx    <= sat_inc(idx, IDX_LIM);
              st     <= ST_TX;
            end else begin
              pull_q <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            sh      <= {sh[6:0], sda_s_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall_i && byte_in) begin
            pull_q  <= 1'b1;
            bit_cnt <= '0;
            idx     <= sat_inc(idx, IDX_LIM);
            st      <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            pull_q <= 1'b0;
            st     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall_i) begin
            if (byte_in) begin
              pull_q  <= 1'b0;
              bit_cnt <= '0;
              st      <= ST_TX_ACK;
            end else begin
              pull_q <= ~txsh[7];
              txsh   <= txsh << 1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            m_ack <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (m_ack) begin
              pull_q <= ~tx_item[7];
              txsh   <= tx_item << 1;
              idx    <= sat_inc(idx, IDX_LIM);
              st     <= ST_TX;
            end else begin
              pull_q <= 1'b0;
              st     <= ST_IDLE;
            end
          end
        end
        default: begin
          st     <= ST_IDLE;
          pull_q <= 1'b0;
        end
      endcase
    end
  end

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX_ACK && scl_fall_i && !m_ack && !start_i && !stop_i)
      |=> (st == ST_IDLE && !sda_pull_o));

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o);

  // R11
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> !rw_q);

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [NUM_REGS*8-1:0] rst_val_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       bus_start;
  logic       bus_stop;
  logic       we;
  logic [7:0] widx;
  logic [7:0] wdata;
  logic [7:0] ridx;
  logic [7:0] rdata;

  cfgi2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  cfgi2c_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_s_i    (sda_s),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .rdata_i    (rdata),
    .sda_pull_o (sda_pull_o),
    .we_o       (we),
    .widx_o     (widx),
    .wdata_o    (wdata),
    .ridx_o     (ridx)
  );

  cfgi2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_val_i (rst_val_i),
    .we_i      (we),
    .widx_i    (widx),
    .wdata_i   (wdata),
    .ridx_i    (ridx),
    .rdata_o   (rdata),
    .regs_o    (regs_o)
  );

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !scl_rise && !bus_start && !bus_stop) |=> $stable(sda_pull_o));

endmodule

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;

  localparam int Q = 8;
  localparam logic [47:0] RST_IMG = 48'hA5_3C_96_0F_81_00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_pull = 1'b0;
  logic        sda_line;
  logic        sda_pull_o;
  logic [47:0] regs_o;
  logic [7:0]  exp_r [6];
  int          n_chk = 0;
  int          n_err = 0;
  int          r10_bad = 0;
  logic        scl_prev = 1'b1;
  logic        pull_prev = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = !(m_pull || sda_pull_o);

  cfg_i2c_slave u_cfg_i2c_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull_o),
    .rst_val_i  (RST_IMG),
    .regs_o     (regs_o)
  );

  // R10 monitor: pull enable must not move across a sample pair with SCL high.
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (sda_pull_o != pull_prev)) r10_bad++;
    scl_prev  <= scl;
    pull_prev <= sda_pull_o;
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] want);
    n_chk++;
    if (got !== want) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, want);
    end
  endtask

  function automatic logic [47:0] exp_img();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = exp_r[k];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_pull = 1'b0; tick(Q);
    scl = 1'b1;    tick(Q);
    m_pull = 1'b1; tick(Q);
    scl = 1'b0;    tick(Q);
  endtask

  task automatic bus_stop();
    m_pull = 1'b1; tick(Q);
    scl = 1'b1;    tick(Q);
    m_pull = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_pull = !b[i]; tick(Q);
      scl = 1'b1;     tick(2*Q);
      scl = 1'b0;     tick(Q);
    end
    m_pull = 1'b0; tick(Q);
    scl = 1'b1;    tick(Q);
    ack = !sda_line; tick(Q);
    scl = 1'b0;    tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl = 1'b0; tick(Q);
    end
    m_pull = give_ack; tick(Q);
    scl = 1'b1;        tick(2*Q);
    scl = 1'b0;        tick(Q);
    m_pull = 1'b0;
  endtask

  task automatic read_all(input string tag);
    logic       a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    chk({tag, " R2 read address ack"}, a, 1'b1);
    recv_byte(1'b1, b);
    chk({tag, " R7 byte count"}, b, 8'h06);
    for (int k = 0; k < 6; k++) begin
      recv_byte(1'b1, b);
      chk({tag, " R7 read byte"}, b, exp_r[k]);
    end
    recv_byte(1'b0, b);
    chk({tag, " R7 past end"}, b, 8'hFF);
    bus_stop();
    tick(4);
    chk({tag, " R11 bank after read"}, regs_o, exp_img());
  endtask

  logic       a;
  logic [7:0] b;
  logic [7:0] d;
  logic       all_ack;
  logic       released;

  initial begin
    for (int k = 0; k < 6; k++) exp_r[k] = RST_IMG[k*8 +: 8];
    tick(5);
    // R1: reset image and released SDA while reset is held
    chk("R1 bank during reset", regs_o, RST_IMG);
    chk("R1 sda released", sda_pull_o, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 bank after reset", regs_o, RST_IMG);

    read_all("initial");

    // Length sweep: 0..8 data bytes per write, read back after each.
    for (int n = 0; n <= 8; n++) begin
      bus_start();
      send_byte(8'hD2, a);
      chk("R2 write address ack", a, 1'b1);
      send_byte(8'h00, a);
      chk("R3 command code ack", a, 1'b1);
      send_byte(8'(n), a);
      chk("R3 byte count ack", a, 1'b1);
      all_ack = 1'b1;
      for (int k = 0; k < n; k++) begin
        d = 8'(n * 37 + k * 91 + 5);
        send_byte(d, a);
        all_ack &= a;
        if (k < 6) exp_r[k] = d;
      end
      chk("R4 R6 data acks", all_ack, 1'b1);
      bus_stop();
      tick(4);
      chk("R4 R5 bank after stop", regs_o, exp_img());
      read_all("sweep");
    end

    // R5: data byte cut short by a Stop is not written.
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h06, a);
    for (int i = 0; i < 4; i++) begin
      m_pull = i[0]; tick(Q);
      scl = 1'b1;    tick(2*Q);
      scl = 1'b0;    tick(Q);
    end
    bus_stop();
    tick(4);
    chk("R5 partial byte dropped", regs_o, exp_img());

    // R2: foreign addresses get no ack and write nothing.
    for (int t = 0; t < 6; t++) begin
      logic [7:0] adr;
      case (t)
        0: adr = 8'hD0;
        1: adr = 8'hD1;
        2: adr = 8'hD4;
        3: adr = 8'h52;
        4: adr = 8'hD6;
        default: adr = 8'h53;
      endcase
      bus_start();
      send_byte(adr, a);
      chk("R2 foreign address nack", a, 1'b0);
      all_ack = 1'b0;
      for (int k = 0; k < 3; k++) begin
        send_byte(8'(8'h11 * (k + 1)), a);
        all_ack |= a;
      end
      chk("R2 bytes after foreign address nack", all_ack, 1'b0);
      bus_stop();
      tick(4);
      chk("R2 bank after foreign address", regs_o, exp_img());
    end

    // R9: repeated Start restarts a write at the command code.
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h06, a);
    send_byte(8'h5A, a);
    exp_r[0] = 8'h5A;
    bus_start();
    send_byte(8'hD2, a);
    chk("R9 address after repeated start", a, 1'b1);
    send_byte(8'h77, a);
    send_byte(8'h88, a);
    send_byte(8'hC3, a);
    exp_r[0] = 8'hC3;
    bus_stop();
    tick(4);
    chk("R9 write pointer restarted", regs_o, exp_img());

    // R9: repeated Start restarts a read at the byte count.
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b);
    chk("R9 first read byte", b, exp_r[0]);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b);
    chk("R9 read restarts with count", b, 8'h06);
    recv_byte(1'b0, b);
    chk("R9 read byte 0 again", b, exp_r[0]);
    bus_stop();

    // R8: host NACK ends the read; further SCL pulses see SDA released.
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b);
    released = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      released &= sda_line;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    chk("R8 sda released after host nack", released, 1'b1);
    bus_stop();
    tick(4);
    chk("R11 bank after nack read", regs_o, exp_img());

    chk("R10 pull steady while scl high", r10_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule